// File: doc/BRIEF.md
# Board Status and Control Registers

This block is a small register file that a processor on an evaluation board reaches over a simple 32-bit read/write strobe bus. It decodes one 64 KiB window and exposes five word locations. Two of them are read-only: a fixed build date code and the processor clock rate in Hz, and both values are parameters. A third holds the LED pattern that drives the board's LED pins. A fourth shows the DIP switch inputs after a two-flop synchronizer. The fifth is a reset doorbell: writing the magic word there raises a one-cycle board reset request toward the board's reset controller.

Each access is a single full-word transfer. `bus_sel` marks the cycle and `bus_wr` gives its direction. A write takes effect on the clock edge that samples it. A read returns its data one cycle later, with `bus_rvalid` high for that one cycle. Address bits [1:0] take no part in the decode. Any location that is not decoded reads as zero, and writes to it are dropped.

Top module: `board_ctrl_regs`

## Requirements
- R1: A read of offset 0x0 returns DATE_CODE (default 32'h09272011). A write to 0x0 leaves that value unchanged.
- R2: A read of offset 0x4 returns CLK_HZ (default 10000000).
- R3: A write to offset 0x8 loads wdata[LED_W-1:0] into the LED register on the edge that samples it, and `led_out` shows the new value after that edge (1 = LED on). A read of 0x8 returns the LED value zero-extended to 32 bits.
- R4: A read of offset 0xC returns the synchronized switch value zero-extended (1 = switch on). A write to 0xC has no effect.
- R5: A write of exactly 32'h0000DEAD to offset 0x10 makes `board_rst_req` high for exactly the one cycle after the write.
- R6: A write of any other value to 0x10 raises no request and changes no other register.
- R7: Any word offset from 0x14 up to 0xFFFC reads zero, and so does a read of 0x10. Writes to these offsets change nothing.
- R8: While `rst_n` is low, `led_out`, `board_rst_req` and `bus_rvalid` are 0 and the synchronizer holds zero. The first reads after release therefore return switch value 0.
- R9: A change on `sw_in` passes through two flops. A read strobed in the same cycle as the first flop's capture, or in the cycle after it, still returns the old value. A read strobed one cycle later returns the new value.
- R10: A read strobe with `bus_wr` low gives `bus_rvalid` = 1 and the data in the next cycle. `bus_rdata` is 0 whenever `bus_rvalid` is 0, and address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when not valid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| sw_in | input | SW_W (8) | Raw DIP switch inputs, asynchronous |
| led_out | output | LED_W (8) | LED drive, 1 = on |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
A broken decode shows up in the first read that follows the bad access, one cycle after its strobe. It appears as a wrong constant, as a nonzero value from an empty offset, or as an LED value disturbed by a write that was meant for another location. A wrong comparison against the magic word shows up as a missing or stray `board_rst_req` in the cycle right after the doorbell write. A synchronizer with the wrong depth moves the point at which a new switch value first appears in reads by one or more cycles. A fixed sequence of reads after a switch change catches that shift.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam logic [31:0] RST_MAGIC = 32'h0000_DEAD;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATE, SEL_FREQ, SEL_LED, SEL_SW, SEL_RST
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [31:0] idx);
    case (idx)
      32'd0:   return SEL_DATE;
      32'd1:   return SEL_FREQ;
      32'd2:   return SEL_LED;
      32'd3:   return SEL_SW;
      32'd4:   return SEL_RST;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_magic(input logic [31:0] d);
    return d == RST_MAGIC;
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic [IDX_W-1:0] word_idx,
  output reg_sel_e         hit
);
  always_comb hit = decode_word(32'(word_idx));
endmodule

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
  import bcr_pkg::*;
#(
  parameter logic [31:0] DATE_CODE = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ    = 32'd10_000_000,
  parameter int          LED_W     = 8,
  parameter int          SW_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_e         hit,
  input  logic             wr_evt,
  input  logic             rd_evt,
  input  logic [31:0]      wdata,
  input  logic [SW_W-1:0]  sw_val,
  output logic [LED_W-1:0] led_q,
  output logic [31:0]      rdata,
  output logic             rvalid
);
  logic        led_wr_evt;
  logic [31:0] rd_mux;

  assign led_wr_evt = wr_evt && (hit == SEL_LED);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          led_q <= '0;
    else if (led_wr_evt) led_q <= wdata[LED_W-1:0];

  always_comb begin
    case (hit)
      SEL_DATE: rd_mux = DATE_CODE;
      SEL_FREQ: rd_mux = CLK_HZ;
      SEL_LED:  rd_mux = 32'(led_q);
      SEL_SW:   rd_mux = 32'(sw_val);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_evt;
      rdata  <= rd_evt ? rd_mux : '0;
    end
endmodule

// File: rtl/bcr_rst_pulse.sv
module bcr_rst_pulse
  import bcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_wr_evt,
  input  logic [31:0] wdata,
  output logic        pulse
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= rst_wr_evt && is_magic(wdata);
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter logic [31:0] DATE_CODE = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ    = 32'd10_000_000,
  parameter int          ADDR_W    = 16,
  parameter int          LED_W     = 8,
  parameter int          SW_W      = 8,
  parameter int          SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [SW_W-1:0]   sw_in,
  output logic [LED_W-1:0]  led_out,
  output logic              board_rst_req
);
  localparam int IDX_W = ADDR_W - 2;

  reg_sel_e        hit;
  logic            wr_evt, rd_evt, rst_wr_evt;
  logic [SW_W-1:0] sw_sync;
  logic            addr_lo_unused;

  assign wr_evt         = bus_sel && bus_wr;
  assign rd_evt         = bus_sel && !bus_wr;
  assign rst_wr_evt     = wr_evt && (hit == SEL_RST);
  assign addr_lo_unused = ^bus_addr[1:0];

  bcr_decode #(.IDX_W(IDX_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .hit      (hit)
  );

  bcr_sync #(.W(SW_W), .STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sw_in),
    .dout (sw_sync)
  );

  bcr_regfile #(
    .DATE_CODE(DATE_CODE), .CLK_HZ(CLK_HZ), .LED_W(LED_W), .SW_W(SW_W)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .wr_evt(wr_evt),
    .rd_evt(rd_evt),
    .wdata (bus_wdata),
    .sw_val(sw_sync),
    .led_q (led_out),
    .rdata (bus_rdata),
    .rvalid(bus_rvalid)
  );

  bcr_rst_pulse u_rp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_wr_evt(rst_wr_evt),
    .wdata     (bus_wdata),
    .pulse     (board_rst_req)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
#(
  parameter logic [31:0] DATE_CODE = 32'h0927_2011,
  parameter int          ADDR_W    = 16,
  parameter int          LED_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [LED_W-1:0]  led_out,
  input logic              board_rst_req
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] w;
  assign w = bus_addr[ADDR_W-1:2];

  assert_date_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && w == IDX_W'(0)) |=> bus_rdata == DATE_CODE);

  assert_led_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && w == IDX_W'(2)) |=> led_out == $past(bus_wdata[LED_W-1:0]));

  assert_led_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && w == IDX_W'(2)) |=> $stable(led_out));

  assert_magic_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && w == IDX_W'(4) && bus_wdata == RST_MAGIC) |=> board_rst_req);

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> $past(bus_sel && bus_wr && w == IDX_W'(4) && bus_wdata == RST_MAGIC));

  assert_other_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && w == IDX_W'(4) && bus_wdata != RST_MAGIC) |=> !board_rst_req);

  assert_undecoded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && w >= IDX_W'(4)) |=> bus_rdata == 32'd0);

  assert_reset_R8: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (led_out == '0 && !board_rst_req && !bus_rvalid));

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == 32'd0);
endmodule

bind board_ctrl_regs bcr_checker #(
  .DATE_CODE(DATE_CODE), .ADDR_W(ADDR_W), .LED_W(LED_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .led_out      (led_out),
  .board_rst_req(board_rst_req)
);

// File: tb/sim_board_ctrl_regs.sv
module sim_board_ctrl_regs;
  localparam time CLK_PERIOD = 10;
  localparam logic [31:0] EXP_DATE = 32'h0927_2011;
  localparam logic [31:0] EXP_FREQ = 32'd10_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  sw_in, led_out;
  logic        board_rst_req;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  board_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sw_in(sw_in), .led_out(led_out),
    .board_rst_req(board_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && bus_rvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; sw_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R8 led in reset", 32'(led_out), 32'd0);
    chk("R8 rst_req in reset", 32'(board_rst_req), 32'd0);
    chk("R8 rvalid in reset", 32'(bus_rvalid), 32'd0);
    rst_n = 1'b1;
    bus_read(16'h000C, 32'h0, "R8 switch zero after release");
    bus_read(16'h000C, 32'h0, "R9 switch still in synchronizer");
    bus_read(16'h000C, 32'hFF, "R4 switch value");
    bus_read(16'h0000, EXP_DATE, "R1 date code");
    bus_read(16'h0004, EXP_FREQ, "R2 clock rate");
    bus_write(16'h0008, 32'h0000_005A);
    chk("R3 led_out after write", 32'(led_out), 32'h5A);
    bus_read(16'h0008, 32'h5A, "R3 led readback");
    bus_read(16'h000B, 32'h5A, "R10 low address bits ignored");
    bus_write(16'h0008, 32'hFFFF_FF3C);
    bus_read(16'h0008, 32'h3C, "R3 led zero-extended");
    bus_write(16'h0000, 32'h1234_5678);
    bus_read(16'h0000, EXP_DATE, "R1 date after write");
    bus_write(16'h000C, 32'h0);
    bus_read(16'h000C, 32'hFF, "R4 switch after write");
    bus_write(16'h0020, 32'h11);
    bus_read(16'h0008, 32'h3C, "R7 undecoded write dropped");
    bus_read(16'h0020, 32'h0, "R7 undecoded read");
    bus_read(16'hFFFC, 32'h0, "R7 top of window");
    bus_read(16'h0010, 32'h0, "R7 reset word reads zero");
    @(negedge clk);
    chk("R10 rvalid idle", 32'(bus_rvalid), 32'd0);
    chk("R10 rdata idle", bus_rdata, 32'd0);
    bus_write(16'h0010, 32'h0000_DEAD);
    chk("R5 pulse high", 32'(board_rst_req), 32'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(board_rst_req), 32'd0);
    bus_write(16'h0010, 32'h0000_DEAE);
    chk("R6 near value ignored", 32'(board_rst_req), 32'd0);
    bus_write(16'h0010, 32'h0001_DEAD);
    chk("R6 upper bits ignored", 32'(board_rst_req), 32'd0);
    bus_read(16'h0008, 32'h3C, "R6 led untouched");
    sw_in = 8'hA5;
    bus_read(16'h000C, 32'hFF, "R9 old value, first stage");
    bus_read(16'h000C, 32'hFF, "R9 old value, second stage");
    bus_read(16'h000C, 32'hA5, "R9 new value");
    repeat (2) @(negedge clk);
    chk("R10 all reads answered", 32'(exp_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule